// File: doc/BRIEF.md
# Register Rename Unit with Deferred Physical Binding

This unit renames one instruction per cycle for an in-order-issue pipeline whose results complete out of order. All values, committed and speculative, live in one shared physical register file. A map table gives every architectural register its current location. That location is either a physical register index, or a virtual tag for a result that has not been produced yet. Each entry carries one flag that says which kind it holds, and a 5-bit index.

At rename, the unit reads the source locations and takes a free tag for the destination. It then points the destination's map entry at that tag. A physical register is not claimed at rename. It is taken from the free pool only when the producing unit writes its result back. At that moment the unit records the tag-to-register binding, turns every map entry that holds the tag into the physical index, and drives the pair out so that waiting consumers can update themselves.

Commit releases the previous committed tag and physical register of the destination, and records the new tag and its bound register in a committed copy of the map. A flush copies the committed map back into the live map and returns every tag and register that the committed copy does not use. The map table has a single shared source read port by default. An instruction with two sources therefore takes two cycles.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i reads as physical (flag 1) with index i. Tags and physical registers numbered NUM_ARCH and up are free, and the ones below NUM_ARCH are in use.
- R2: A rename with a destination is given the lowest-numbered free tag, shown on `dstTag`. From the next cycle, that destination reads as a tag (flag 0) with that index.
- R3: A source that names the destination of the same instruction reads the mapping that held before the instruction, not its new tag.
- R4: When no tag is free, a rename with a destination is held off (`renReady` low). A rename without a destination still proceeds.
- R5: A granted writeback receives the lowest-numbered free physical register on `wbPhys`. Every map entry that held the written tag reads as that physical register from the next cycle.
- R6: When no physical register is free, the writeback gets `wbRetry` high and `wbGrant` low, and the map keeps the tag.
- R7: A source whose mapping is the tag being granted in the same cycle reads as the granted physical register. This also holds for a source captured in an earlier cycle of a split read.
- R8: With one shared read port, an instruction with two sources shows `renReady` low in its first cycle and high in its second. An instruction with one source or none completes in a single cycle.
- R9: A commit returns the previous committed tag and physical register of its architectural register to the free pools, and records the committing tag's bound register as committed.
- R10: A flush causes no rename and no writeback grant in its cycle. Afterwards every architectural register reads the committed physical register, and every tag and register that the committed copy does not use is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | An instruction is offered for rename; held until `renReady` |
| renSrcAEn | input | 1 | First source is used |
| renSrcA | input | 4 | First source architectural register |
| renSrcBEn | input | 1 | Second source is used |
| renSrcB | input | 4 | Second source architectural register |
| renDstEn | input | 1 | Instruction writes a destination |
| renDst | input | 4 | Destination architectural register |
| renReady | output | 1 | Rename completes this cycle |
| srcAPhys | output | 1 | First source location is physical (1) or a tag (0) |
| srcAIdx | output | 5 | First source physical index or tag |
| srcBPhys | output | 1 | Second source location kind |
| srcBIdx | output | 5 | Second source physical index or tag |
| dstTag | output | 5 | Tag given to the destination |
| wbValid | input | 1 | A result for `wbTag` is ready |
| wbTag | input | 5 | Tag of the result |
| wbGrant | output | 1 | Writeback accepted; also the binding broadcast |
| wbRetry | output | 1 | Writeback refused; the result must be held |
| wbPhys | output | 5 | Physical register bound to `wbTag` |
| cmtValid | input | 1 | Oldest instruction commits |
| cmtArch | input | 4 | Its destination architectural register |
| cmtTag | input | 5 | Its destination tag |
| flush | input | 1 | Discard all speculative state |

## Verification
The bench exhausts the tag pool and then the physical pool. This exposes a design that fails to stall, grants a register it does not have, or lets a refused writeback still change the map. It renames every register with itself as the source: a design that forwards the new tag to its own source reports a tag where the old physical index belongs. It lands a writeback in the same cycle as a direct read and in the second cycle of a split read. A design without the bypass returns a tag that will never be broadcast again. After a flush, it checks the restored map and the order of the tags and registers that come back. A design that frees the wrong set hands out a different index.

// File: rtl/rrn_pkg.sv
package rrn_pkg;
  typedef struct packed {
    logic doRename;
    logic doWb;
    logic doCmt;
    logic doFlush;
    logic selB;
    logic capA;
    logic useHeld;
  } rrnStrobes_t;
endpackage

// File: rtl/rrn_lowest_free.sv
module rrn_lowest_free #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] vec,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/rrn_ctrl.sv
module rrn_ctrl
  import rrn_pkg::*;
#(
  parameter int RD_PORTS = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        renValid,
  input  logic        renSrcAEn,
  input  logic        renSrcBEn,
  input  logic        renDstEn,
  input  logic        tagAvail,
  input  logic        physAvail,
  input  logic        wbValid,
  input  logic        cmtValid,
  input  logic        flush,
  output rrnStrobes_t stb,
  output logic        renReady,
  output logic        wbGrant,
  output logic        wbRetry
);
  localparam bit SPLIT = (RD_PORTS < 2);

  logic phaseHeld;
  logic dstOk;
  logic needSplit;

  always_comb begin
    dstOk       = !renDstEn || tagAvail;
    needSplit   = SPLIT && renSrcAEn && renSrcBEn;
    stb         = '0;
    stb.doFlush = flush;
    stb.doWb    = wbValid && physAvail && !flush;
    stb.doCmt   = cmtValid && !flush;
    if (!flush && renValid) begin
      if (phaseHeld) begin
        stb.selB     = 1'b1;
        stb.useHeld  = 1'b1;
        stb.doRename = dstOk;
      end else if (needSplit) begin
        stb.capA = 1'b1;
      end else begin
        stb.selB     = !renSrcAEn;
        stb.doRename = dstOk;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             phaseHeld <= 1'b0;
    else if (flush)        phaseHeld <= 1'b0;
    else if (stb.capA)     phaseHeld <= 1'b1;
    else if (stb.doRename) phaseHeld <= 1'b0;
  end

  assign renReady = stb.doRename;
  assign wbGrant  = stb.doWb;
  assign wbRetry  = wbValid && !stb.doWb;

  // R8: a two-source rename on a shared port completes only after a capture cycle
  p_split_two_cycles_r8: assert property (@(posedge clk) disable iff (!rstN)
    (SPLIT && renReady && renSrcAEn && renSrcBEn) |-> $past(stb.capA));

  // R4: an empty tag pool holds off a rename that needs a destination
  p_stall_no_tag_r4: assert property (@(posedge clk) disable iff (!rstN)
    (renValid && renDstEn && !tagAvail) |-> !renReady);

  // R6: an empty physical pool turns writeback into a retry
  p_retry_when_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !physAvail) |-> (wbRetry && !wbGrant));
endmodule

// File: rtl/rrn_datapath.sv
module rrn_datapath
  import rrn_pkg::*;
#(
  parameter int NUM_ARCH = 16,
  parameter int NUM_PHYS = 24,
  parameter int NUM_TAGS = 32,
  parameter int RD_PORTS = 1,
  parameter int ARCH_W   = 4,
  parameter int IDX_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  rrnStrobes_t       stb,
  input  logic              renDstEn,
  input  logic [ARCH_W-1:0] renSrcA,
  input  logic [ARCH_W-1:0] renSrcB,
  input  logic [ARCH_W-1:0] renDst,
  input  logic [IDX_W-1:0]  wbTag,
  input  logic [ARCH_W-1:0] cmtArch,
  input  logic [IDX_W-1:0]  cmtTag,
  output logic              tagAvail,
  output logic              physAvail,
  output logic              srcAPhys,
  output logic [IDX_W-1:0]  srcAIdx,
  output logic              srcBPhys,
  output logic [IDX_W-1:0]  srcBIdx,
  output logic [IDX_W-1:0]  dstTag,
  output logic [IDX_W-1:0]  wbPhys
);
  // live map: location kind flag and index
  logic [NUM_ARCH-1:0] mapPhys;
  logic [IDX_W-1:0]    mapIdx    [NUM_ARCH];
  // committed copy
  logic [IDX_W-1:0]    cmtTagQ   [NUM_ARCH];
  logic [IDX_W-1:0]    cmtPhysQ  [NUM_ARCH];
  // tag to physical binding
  logic [NUM_TAGS-1:0] bindValid;
  logic [IDX_W-1:0]    bindPhys  [NUM_TAGS];
  // free pools
  logic [NUM_TAGS-1:0] tagFree;
  logic [NUM_PHYS-1:0] physFree;
  // captured first source for split reads
  logic [IDX_W:0]      held;

  logic [IDX_W:0] aRaw, bRaw, aOut, bOut;
  logic [NUM_TAGS-1:0] cmtTagUsed;
  logic [NUM_PHYS-1:0] cmtPhysUsed;
  logic [IDX_W-1:0] oldTag, oldPhys;

  rrn_lowest_free #(.N(NUM_TAGS), .W(IDX_W)) u_tagPick (
    .vec(tagFree), .any(tagAvail), .idx(dstTag));

  rrn_lowest_free #(.N(NUM_PHYS), .W(IDX_W)) u_physPick (
    .vec(physFree), .any(physAvail), .idx(wbPhys));

  function automatic logic [IDX_W:0] fwd(input logic [IDX_W:0] e, input logic hit,
                                         input logic [IDX_W-1:0] tag,
                                         input logic [IDX_W-1:0] phys);
    if (hit && !e[IDX_W] && e[IDX_W-1:0] == tag) return {1'b1, phys};
    return e;
  endfunction

  generate
    if (RD_PORTS >= 2) begin : g_twoPort
      assign aRaw = {mapPhys[renSrcA], mapIdx[renSrcA]};
      assign bRaw = {mapPhys[renSrcB], mapIdx[renSrcB]};
    end else begin : g_onePort
      logic [ARCH_W-1:0] portAddr;
      logic [IDX_W:0]    portData;
      assign portAddr = stb.selB ? renSrcB : renSrcA;
      assign portData = {mapPhys[portAddr], mapIdx[portAddr]};
      assign aRaw     = stb.useHeld ? held : portData;
      assign bRaw     = portData;
    end
  endgenerate

  assign aOut = fwd(aRaw, stb.doWb, wbTag, wbPhys);
  assign bOut = fwd(bRaw, stb.doWb, wbTag, wbPhys);
  assign {srcAPhys, srcAIdx} = aOut;
  assign {srcBPhys, srcBIdx} = bOut;

  assign oldTag  = cmtTagQ[cmtArch];
  assign oldPhys = cmtPhysQ[cmtArch];

  always_comb begin
    cmtTagUsed  = '0;
    cmtPhysUsed = '0;
    for (int a = 0; a < NUM_ARCH; a++) begin
      cmtTagUsed[cmtTagQ[a]]   = 1'b1;
      cmtPhysUsed[cmtPhysQ[a]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) held <= '0;
    else if (stb.capA || stb.useHeld) held <= aOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < NUM_ARCH; a++) begin
        mapPhys[a]  <= 1'b1;
        mapIdx[a]   <= IDX_W'(a);
        cmtTagQ[a]  <= IDX_W'(a);
        cmtPhysQ[a] <= IDX_W'(a);
      end
      for (int t = 0; t < NUM_TAGS; t++) begin
        bindValid[t] <= (t < NUM_ARCH);
        bindPhys[t]  <= (t < NUM_ARCH) ? IDX_W'(t) : '0;
        tagFree[t]   <= (t >= NUM_ARCH);
      end
      for (int p = 0; p < NUM_PHYS; p++) physFree[p] <= (p >= NUM_ARCH);
    end else if (stb.doFlush) begin
      for (int a = 0; a < NUM_ARCH; a++) begin
        mapPhys[a] <= 1'b1;
        mapIdx[a]  <= cmtPhysQ[a];
      end
      tagFree   <= ~cmtTagUsed;
      physFree  <= ~cmtPhysUsed;
      bindValid <= cmtTagUsed;
    end else begin
      if (stb.doWb) begin
        bindValid[wbTag] <= 1'b1;
        bindPhys[wbTag]  <= wbPhys;
        physFree[wbPhys] <= 1'b0;
        for (int a = 0; a < NUM_ARCH; a++) begin
          if (!mapPhys[a] && mapIdx[a] == wbTag) begin
            mapPhys[a] <= 1'b1;
            mapIdx[a]  <= wbPhys;
          end
        end
      end
      if (stb.doRename && renDstEn) begin
        mapPhys[renDst] <= 1'b0;
        mapIdx[renDst]  <= dstTag;
        tagFree[dstTag] <= 1'b0;
      end
      if (stb.doCmt) begin
        tagFree[oldTag]   <= 1'b1;
        bindValid[oldTag] <= 1'b0;
        physFree[oldPhys] <= 1'b1;
        cmtTagQ[cmtArch]  <= cmtTag;
        cmtPhysQ[cmtArch] <= bindPhys[cmtTag];
      end
    end
  end

  // R2: the renamed destination points at its new tag after the edge
  p_rename_marks_tag_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doRename && renDstEn && !stb.doFlush) |=>
      (!mapPhys[$past(renDst)] && mapIdx[$past(renDst)] == $past(dstTag)));

  // R5: a granted register leaves the free pool and the tag becomes bound
  p_grant_binds_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.doWb |=> (!physFree[$past(wbPhys)] && bindValid[$past(wbTag)]));

  // R9: committing needs a bound tag, and the released resources are not yet free
  p_commit_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.doCmt |-> (bindValid[cmtTag] && !tagFree[oldTag] && !physFree[oldPhys]));

  // R10: after a flush every live entry names a physical register
  p_flush_all_phys_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.doFlush) |-> (&mapPhys));
endmodule

// File: rtl/rename_unit.sv
module rename_unit
  import rrn_pkg::*;
#(
  parameter int NUM_ARCH = 16,
  parameter int NUM_PHYS = 24,
  parameter int NUM_TAGS = 32,
  parameter int RD_PORTS = 1,
  localparam int ARCH_W  = $clog2(NUM_ARCH),
  localparam int IDX_W   = $clog2((NUM_TAGS > NUM_PHYS) ? NUM_TAGS : NUM_PHYS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              renValid,
  input  logic              renSrcAEn,
  input  logic [ARCH_W-1:0] renSrcA,
  input  logic              renSrcBEn,
  input  logic [ARCH_W-1:0] renSrcB,
  input  logic              renDstEn,
  input  logic [ARCH_W-1:0] renDst,
  output logic              renReady,
  output logic              srcAPhys,
  output logic [IDX_W-1:0]  srcAIdx,
  output logic              srcBPhys,
  output logic [IDX_W-1:0]  srcBIdx,
  output logic [IDX_W-1:0]  dstTag,
  input  logic              wbValid,
  input  logic [IDX_W-1:0]  wbTag,
  output logic              wbGrant,
  output logic              wbRetry,
  output logic [IDX_W-1:0]  wbPhys,
  input  logic              cmtValid,
  input  logic [ARCH_W-1:0] cmtArch,
  input  logic [IDX_W-1:0]  cmtTag,
  input  logic              flush
);
  rrnStrobes_t stb;
  logic tagAvail, physAvail;

  rrn_ctrl #(.RD_PORTS(RD_PORTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .renValid(renValid), .renSrcAEn(renSrcAEn),
    .renSrcBEn(renSrcBEn), .renDstEn(renDstEn), .tagAvail(tagAvail),
    .physAvail(physAvail), .wbValid(wbValid), .cmtValid(cmtValid), .flush(flush),
    .stb(stb), .renReady(renReady), .wbGrant(wbGrant), .wbRetry(wbRetry));

  rrn_datapath #(
    .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_TAGS(NUM_TAGS),
    .RD_PORTS(RD_PORTS), .ARCH_W(ARCH_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .renDstEn(renDstEn),
    .renSrcA(renSrcA), .renSrcB(renSrcB), .renDst(renDst), .wbTag(wbTag),
    .cmtArch(cmtArch), .cmtTag(cmtTag), .tagAvail(tagAvail), .physAvail(physAvail),
    .srcAPhys(srcAPhys), .srcAIdx(srcAIdx), .srcBPhys(srcBPhys), .srcBIdx(srcBIdx),
    .dstTag(dstTag), .wbPhys(wbPhys));
endmodule

// File: tb/rename_unit_bench.sv
`timescale 1ns/1ps
module rename_unit_bench;
  logic clk = 1'b0;
  logic rstN;
  logic renValid, renSrcAEn, renSrcBEn, renDstEn;
  logic [3:0] renSrcA, renSrcB, renDst;
  logic renReady, srcAPhys, srcBPhys;
  logic [4:0] srcAIdx, srcBIdx, dstTag;
  logic wbValid, wbGrant, wbRetry;
  logic [4:0] wbTag, wbPhys;
  logic cmtValid;
  logic [3:0] cmtArch;
  logic [4:0] cmtTag;
  logic flush;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rename_unit u_rename_unit (
    .clk(clk), .rstN(rstN), .renValid(renValid), .renSrcAEn(renSrcAEn),
    .renSrcA(renSrcA), .renSrcBEn(renSrcBEn), .renSrcB(renSrcB),
    .renDstEn(renDstEn), .renDst(renDst), .renReady(renReady),
    .srcAPhys(srcAPhys), .srcAIdx(srcAIdx), .srcBPhys(srcBPhys), .srcBIdx(srcBIdx),
    .dstTag(dstTag), .wbValid(wbValid), .wbTag(wbTag), .wbGrant(wbGrant),
    .wbRetry(wbRetry), .wbPhys(wbPhys), .cmtValid(cmtValid), .cmtArch(cmtArch),
    .cmtTag(cmtTag), .flush(flush));

  task automatic idle();
    renValid = 0; renSrcAEn = 0; renSrcBEn = 0; renDstEn = 0;
    renSrcA = 0; renSrcB = 0; renDst = 0;
    wbValid = 0; wbTag = 0; cmtValid = 0; cmtArch = 0; cmtTag = 0; flush = 0;
  endtask

  task automatic go();
    @(negedge clk);
    idle();
  endtask

  task automatic ren(input logic aEn, input int a, input logic bEn, input int b,
                     input logic dEn, input int d);
    renValid = 1; renSrcAEn = aEn; renSrcA = 4'(a); renSrcBEn = bEn;
    renSrcB = 4'(b); renDstEn = dEn; renDst = 4'(d);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // location encoded as flag*32 + index
  function automatic int loc(input logic p, input logic [4:0] i);
    return int'(p) * 32 + int'(i);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    // R1: reset mapping of every architectural register
    for (int i = 0; i < 16; i++) begin
      go(); ren(1, i, 0, 0, 0, 0); #1;
      chk("R1 ready", int'(renReady), 1);
      chk("R1 map", loc(srcAPhys, srcAIdx), 32 + i);
    end
    // R8: second source alone completes in one cycle on the shared port
    go(); ren(0, 0, 1, 7, 0, 0); #1;
    chk("R8 single B ready", int'(renReady), 1);
    chk("R8 single B map", loc(srcBPhys, srcBIdx), 32 + 7);

    // R2, R3: rename every register with itself as source
    for (int r = 0; r < 16; r++) begin
      go(); ren(1, r, 0, 0, 1, r); #1;
      chk("R2 ready", int'(renReady), 1);
      chk("R2 tag", int'(dstTag), 16 + r);
      chk("R3 old mapping", loc(srcAPhys, srcAIdx), 32 + r);
    end
    // R4: tag pool now empty
    go(); ren(0, 0, 0, 0, 1, 0); #1;
    chk("R4 stall", int'(renReady), 0);
    go(); ren(1, 3, 0, 0, 0, 0); #1;
    chk("R4 no-dst proceeds", int'(renReady), 1);
    chk("R2 map is tag", loc(srcAPhys, srcAIdx), 19);

    // R5, R7: writebacks of tags 16..23 take phys 16..23
    go(); ren(1, 0, 0, 0, 0, 0); wbValid = 1; wbTag = 16; #1;
    chk("R5 grant", int'(wbGrant), 1);
    chk("R5 phys", int'(wbPhys), 16);
    chk("R7 bypass direct", loc(srcAPhys, srcAIdx), 32 + 16);
    for (int k = 1; k < 8; k++) begin
      go(); wbValid = 1; wbTag = 5'(16 + k); #1;
      chk("R5 phys", int'(wbPhys), 16 + k);
    end
    // R6: physical pool empty
    go(); wbValid = 1; wbTag = 24; #1;
    chk("R6 retry", int'(wbRetry), 1);
    chk("R6 no grant", int'(wbGrant), 0);
    go(); ren(1, 8, 0, 0, 0, 0); #1;
    chk("R6 map keeps tag", loc(srcAPhys, srcAIdx), 24);
    go(); ren(1, 5, 0, 0, 0, 0); #1;
    chk("R5 map flipped", loc(srcAPhys, srcAIdx), 32 + 21);

    // R9: commit arch 0 frees tag 0 and phys 0
    go(); cmtValid = 1; cmtArch = 0; cmtTag = 16;
    go(); wbValid = 1; wbTag = 24; #1;
    chk("R9 freed phys reused", int'(wbPhys), 0);
    chk("R9 grant", int'(wbGrant), 1);

    // R8: two sources take two cycles
    go(); ren(1, 0, 1, 1, 1, 2); #1;
    chk("R8 first cycle", int'(renReady), 0);
    go(); ren(1, 0, 1, 1, 1, 2); #1;
    chk("R8 second cycle", int'(renReady), 1);
    chk("R8 src A", loc(srcAPhys, srcAIdx), 32 + 16);
    chk("R8 src B", loc(srcBPhys, srcBIdx), 32 + 17);
    chk("R9 freed tag reused", int'(dstTag), 0);

    // R7: bypass onto a captured source
    go(); cmtValid = 1; cmtArch = 1; cmtTag = 17;
    go(); ren(1, 9, 1, 4, 0, 0); #1;
    chk("R8 split stall", int'(renReady), 0);
    go(); ren(1, 9, 1, 4, 0, 0); wbValid = 1; wbTag = 25; #1;
    chk("R7 held ready", int'(renReady), 1);
    chk("R7 held phys", int'(wbPhys), 1);
    chk("R7 bypass held", loc(srcAPhys, srcAIdx), 32 + 1);
    chk("R7 other src", loc(srcBPhys, srcBIdx), 32 + 20);

    // R10: flush
    go(); ren(1, 3, 0, 0, 0, 0); flush = 1; wbValid = 1; wbTag = 26; #1;
    chk("R10 no rename", int'(renReady), 0);
    chk("R10 no grant", int'(wbGrant), 0);
    go(); ren(1, 2, 0, 0, 0, 0); #1;
    chk("R10 arch2 restored", loc(srcAPhys, srcAIdx), 32 + 2);
    go(); ren(1, 9, 0, 0, 0, 0); #1;
    chk("R10 arch9 restored", loc(srcAPhys, srcAIdx), 32 + 9);
    go(); ren(1, 1, 0, 0, 0, 0); #1;
    chk("R10 arch1 committed", loc(srcAPhys, srcAIdx), 32 + 17);
    go(); ren(1, 0, 0, 0, 0, 0); #1;
    chk("R10 arch0 committed", loc(srcAPhys, srcAIdx), 32 + 16);
    go(); ren(0, 0, 0, 0, 1, 5); #1;
    chk("R10 tag order", int'(dstTag), 0);
    go(); ren(0, 0, 0, 0, 1, 6); #1;
    chk("R10 tag order", int'(dstTag), 1);
    go(); ren(0, 0, 0, 0, 1, 7); #1;
    chk("R10 tag order", int'(dstTag), 18);
    go(); wbValid = 1; wbTag = 0; #1;
    chk("R10 phys order", int'(wbPhys), 0);
    go(); wbValid = 1; wbTag = 1; #1;
    chk("R10 phys order", int'(wbPhys), 1);
    go(); wbValid = 1; wbTag = 18; #1;
    chk("R10 phys order", int'(wbPhys), 18);
    go(); ren(1, 7, 0, 0, 0, 0); #1;
    chk("R5 arch7", loc(srcAPhys, srcAIdx), 32 + 18);

    // R9: commit after flush releases tag 5 and phys 5
    go(); cmtValid = 1; cmtArch = 5; cmtTag = 0;
    go(); ren(1, 5, 0, 0, 1, 8); #1;
    chk("R9 committed read", loc(srcAPhys, srcAIdx), 32 + 0);
    chk("R9 tag returned", int'(dstTag), 5);
    go(); wbValid = 1; wbTag = 5; #1;
    chk("R9 phys returned", int'(wbPhys), 5);
    go(); ren(1, 8, 0, 0, 0, 0); #1;
    chk("R5 arch8", loc(srcAPhys, srcAIdx), 32 + 5);

    go();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule